// File: doc/BRIEF.md
# Single-Port SATA Host Controller Register Block

This block is an AXI4-Lite slave. It holds the global and port control registers of a host bus adapter that serves one SATA port. It decodes a 128 KB address window. Register offsets in that window are answered inside the block. Three memory windows are passed out to external RAMs over a simple port: a one-hot window select, a write enable, a word address inside the window, write data, and one read-data return per window.

The hardware side of the adapter has several inputs into this block:
- It sets port interrupt causes.
- It drives two read-only status levels.
- It sets error bits.
- It clears per-slot issue and active bits as commands leave and finish.
- It acknowledges a controller reset.

Software arms command slots by setting bits and takes interrupts through a two-level scheme. A port cause raises a global pending flag. That flag and a global enable together drive the single `irq` output.

Only one bus transaction is handled at a time. Full 32-bit writes are assumed.

Top module: `hba_regfile`

## Requirements
- R1: Byte offsets 0x08000–0x080FF select RAM window 0 (received frames), 0x09000–0x093FF select window 1 (command list), and 0x10000–0x1FFFF select window 2 (command table). The window is shown as `ram_sel` bit 0, 1 or 2, with `ram_addr` equal to the byte offset inside the window divided by 4. A write pulses `ram_we` with `ram_wdata` equal to the bus data.
- R2: Any offset outside the three windows and the registers listed in R3–R12 reads as zero. Writes to such offsets change nothing and never touch the RAM port. All responses are OKAY (0).
- R3: At offset 0x004, bit 0 is controller reset and bit 1 is global interrupt enable. Writing 1 to bit 0 raises `hba_reset`, and writing 0 to it has no effect. `hw_reset_done` lowers it. Bit 1 is read/write.
- R4: At offset 0x110, port status bits 3, 4, 24 and 30 are set by `hw_is_set` and cleared by writing 1. Bit 6 follows `hw_pcs` and bit 22 follows `hw_prcs`, and writes do not change them. All other bits read 0.
- R5: Offset 0x114 is a 32-bit read/write port interrupt mask that resets to 0.
- R6: At offset 0x008, bit 0 is the pending flag. It becomes 1 whenever the port status (0x110) ANDed with the mask (0x114) is nonzero. Writing 1 clears it only while that masked value is zero.
- R7: `irq` is 1 exactly when the global enable and the pending flag are both 1.
- R8: At offset 0x118, bit 4 is frame-receive enable and bit 0 is start. A write stores start only if the same write also sets bit 4. `port_start` and `port_fre` show the two bits.
- R9: Offset 0x138 (issue, shown on `cmd_issue`) and offset 0x134 (active, shown on `cmd_active`) are 32-bit slot bitmaps. A write sets the bits that are 1 in the data and ignores the zeros. `hw_ci_clr` and `hw_sact_clr` clear the bits they name.
- R10: Offset 0x130 is an error register. `hw_serr_set` sets its bits and writing 1 clears them.
- R11: A register read returns `rvalid` in the cycle after the address handshake. A RAM-window read returns it one cycle later, carrying the RAM data from the cycle after the handshake. `bvalid` follows a write handshake by one cycle.
- R12: Offset 0x000 returns the parameter CAP_VALUE, 0x00C returns 1, and 0x010 returns the parameter VER_VALUE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 17 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 17 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ram_sel | output | 3 | One-hot window select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 14 | Word address inside the window |
| ram_wdata | output | 32 | RAM write data |
| fis_rdata | input | 32 | Window 0 read data |
| cl_rdata | input | 32 | Window 1 read data |
| ct_rdata | input | 32 | Window 2 read data |
| hw_is_set | input | 32 | Port status set pulses |
| hw_pcs | input | 1 | Connect-change level |
| hw_prcs | input | 1 | Phy-ready-change level |
| hw_serr_set | input | 32 | Error set pulses |
| hw_ci_clr | input | 32 | Issue-bit clear pulses |
| hw_sact_clr | input | 32 | Active-bit clear pulses |
| hw_reset_done | input | 1 | Reset completion |
| hba_reset | output | 1 | Controller reset request |
| port_fre | output | 1 | Frame receive enable |
| port_start | output | 1 | Port start |
| cmd_issue | output | 32 | Issue bitmap |
| cmd_active | output | 32 | Active bitmap |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps every port status bit and checks that only the four clearable causes latch and raise `irq`. A design that latched a reserved bit would raise a false interrupt. The bench also writes 1 to the pending flag while the cause is still present; a design that let the flag clear early would lose interrupts. Window edges are probed on both sides, because a decoder that is off by one would send a reserved access to a RAM. The issue bitmap is cleared one slot at a time, and read latency is measured separately for register reads and RAM reads.

// File: rtl/hba_pkg.sv
package hba_pkg;
  localparam int ADDR_W  = 17;
  localparam int DATA_W  = 32;
  localparam int SLOTS   = 32;
  localparam int WIN_N   = 3;
  localparam int WORD_AW = ADDR_W - 3;

  localparam logic [DATA_W-1:0] IS_W1C_MASK = 32'h4100_0018;
  localparam int PCS_BIT  = 6;
  localparam int PRCS_BIT = 22;

  typedef enum logic [2:0] {
    RG_NONE, RG_GLOBAL, RG_PORT, RG_FIS, RG_CLIST, RG_CTBL
  } hba_region_e;

  function automatic hba_region_e hba_region(input logic [ADDR_W-1:0] a);
    if (a[16])                     return RG_CTBL;
    else if (a[15:8] == 8'h80)     return RG_FIS;
    else if (a[15:10] == 6'h24)    return RG_CLIST;
    else if (a[15:8] == 8'h00)     return RG_GLOBAL;
    else if (a[15:7] == 9'h002)    return RG_PORT;
    else                           return RG_NONE;
  endfunction

  function automatic logic [WORD_AW-1:0] hba_word(input logic [ADDR_W-1:0] a,
                                                   input hba_region_e rg);
    case (rg)
      RG_FIS:   return WORD_AW'(a[7:2]);
      RG_CLIST: return WORD_AW'(a[9:2]);
      RG_CTBL:  return a[15:2];
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/hba_win_decode.sv
module hba_win_decode
  import hba_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  output hba_region_e        region,
  output logic [WIN_N-1:0]   win_onehot,
  output logic [WORD_AW-1:0] word
);
  always_comb begin
    region     = hba_region(addr);
    word       = hba_word(addr, region);
    win_onehot = '0;
    case (region)
      RG_FIS:   win_onehot[0] = 1'b1;
      RG_CLIST: win_onehot[1] = 1'b1;
      RG_CTBL:  win_onehot[2] = 1'b1;
      default:  win_onehot = '0;
    endcase
  end
endmodule

// File: rtl/hba_port_irq.sv
module hba_port_irq
  import hba_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] hw_set,
  input  logic              pcs_lvl,
  input  logic              prcs_lvl,
  input  logic              sts_w1c,
  input  logic              ena_wr,
  input  logic              ips_w1c,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sts_view,
  output logic [DATA_W-1:0] ena_q,
  output logic              pending,
  output logic              masked_any
);
  logic [DATA_W-1:0] sts_q;
  logic [DATA_W-1:0] clr_bits;

  assign clr_bits = sts_w1c ? (wdata & IS_W1C_MASK) : '0;

  always_comb begin
    sts_view = sts_q;
    sts_view[PCS_BIT]  = pcs_lvl;
    sts_view[PRCS_BIT] = prcs_lvl;
  end

  assign masked_any = |(sts_view & ena_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q   <= '0;
      ena_q   <= '0;
      pending <= 1'b0;
    end else begin
      sts_q <= ((sts_q & ~clr_bits) | hw_set) & IS_W1C_MASK;
      if (ena_wr) ena_q <= wdata;
      if (masked_any)   pending <= 1'b1;
      else if (ips_w1c) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/hba_regfile.sv
module hba_regfile
  import hba_pkg::*;
#(
  parameter logic [DATA_W-1:0] CAP_VALUE = 32'h4020_1F00,
  parameter logic [DATA_W-1:0] VER_VALUE = 32'h0001_0301
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [WIN_N-1:0]    ram_sel,
  output logic                ram_we,
  output logic [WORD_AW-1:0]  ram_addr,
  output logic [DATA_W-1:0]   ram_wdata,
  input  logic [DATA_W-1:0]   fis_rdata,
  input  logic [DATA_W-1:0]   cl_rdata,
  input  logic [DATA_W-1:0]   ct_rdata,
  input  logic [DATA_W-1:0]   hw_is_set,
  input  logic                hw_pcs,
  input  logic                hw_prcs,
  input  logic [DATA_W-1:0]   hw_serr_set,
  input  logic [SLOTS-1:0]    hw_ci_clr,
  input  logic [SLOTS-1:0]    hw_sact_clr,
  input  logic                hw_reset_done,
  output logic                hba_reset,
  output logic                port_fre,
  output logic                port_start,
  output logic [SLOTS-1:0]    cmd_issue,
  output logic [SLOTS-1:0]    cmd_active,
  output logic                irq
);
  typedef enum logic [1:0] {S_IDLE, S_BRESP, S_RAMWAIT, S_RDATA} bus_state_e;
  bus_state_e state;

  logic wr_go, rd_go;
  logic [ADDR_W-1:0]  dec_addr;
  hba_region_e        region;
  logic [WIN_N-1:0]   win_onehot;
  logic [WORD_AW-1:0] word;
  logic [WIN_N-1:0]   pick_q;
  logic [DATA_W-1:0]  rdata_q, reg_rdata;
  logic [7:0]         off;

  // named events for the checker
  logic ghc_wr, is_w1c_wr, ips_wr, ie_wr, cmd_wr, serr_wr, sact_wr, ci_wr;
  logic gie_q, fre_q, st_q, hr_q;
  logic [DATA_W-1:0] serr_q, p_sts, p_ena;
  logic [SLOTS-1:0]  ci_q, sact_q;
  logic pending, masked_any;

  assign wr_go    = (state == S_IDLE) && s_awvalid && s_wvalid;
  assign rd_go    = (state == S_IDLE) && s_arvalid && !(s_awvalid && s_wvalid);
  assign dec_addr = wr_go ? s_awaddr : s_araddr;
  assign off      = dec_addr[7:0];

  hba_win_decode u_dec (
    .addr(dec_addr), .region(region), .win_onehot(win_onehot), .word(word)
  );

  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign s_arready = rd_go;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign s_bvalid  = (state == S_BRESP);
  assign s_rvalid  = (state == S_RDATA);
  assign s_rdata   = rdata_q;

  assign ram_sel   = (wr_go || rd_go) ? win_onehot : '0;
  assign ram_we    = wr_go && (win_onehot != '0);
  assign ram_addr  = word;
  assign ram_wdata = s_wdata;

  assign ghc_wr    = wr_go && region == RG_GLOBAL && off == 8'h04;
  assign ips_wr    = wr_go && region == RG_GLOBAL && off == 8'h08 && s_wdata[0];
  assign is_w1c_wr = wr_go && region == RG_PORT   && off == 8'h10;
  assign ie_wr     = wr_go && region == RG_PORT   && off == 8'h14;
  assign cmd_wr    = wr_go && region == RG_PORT   && off == 8'h18;
  assign serr_wr   = wr_go && region == RG_PORT   && off == 8'h30;
  assign sact_wr   = wr_go && region == RG_PORT   && off == 8'h34;
  assign ci_wr     = wr_go && region == RG_PORT   && off == 8'h38;

  hba_port_irq u_irq (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_is_set), .pcs_lvl(hw_pcs),
    .prcs_lvl(hw_prcs), .sts_w1c(is_w1c_wr), .ena_wr(ie_wr), .ips_w1c(ips_wr),
    .wdata(s_wdata), .sts_view(p_sts), .ena_q(p_ena), .pending(pending),
    .masked_any(masked_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr_q <= 1'b0; gie_q <= 1'b0; fre_q <= 1'b0; st_q <= 1'b0;
      serr_q <= '0; ci_q <= '0; sact_q <= '0;
    end else begin
      if (ghc_wr && s_wdata[0]) hr_q <= 1'b1;
      else if (hw_reset_done)   hr_q <= 1'b0;
      if (ghc_wr) gie_q <= s_wdata[1];
      if (cmd_wr) begin
        fre_q <= s_wdata[4];
        st_q  <= s_wdata[0] & s_wdata[4];
      end
      serr_q <= (serr_q & ~(serr_wr ? s_wdata : '0)) | hw_serr_set;
      ci_q   <= (ci_q   & ~hw_ci_clr)   | (ci_wr   ? s_wdata : '0);
      sact_q <= (sact_q & ~hw_sact_clr) | (sact_wr ? s_wdata : '0);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (region == RG_GLOBAL) begin
      case (off)
        8'h00:   reg_rdata = CAP_VALUE;
        8'h04:   reg_rdata = {30'd0, gie_q, hr_q};
        8'h08:   reg_rdata = {31'd0, pending};
        8'h0C:   reg_rdata = 32'd1;
        8'h10:   reg_rdata = VER_VALUE;
        default: reg_rdata = '0;
      endcase
    end else if (region == RG_PORT) begin
      case (off)
        8'h10:   reg_rdata = p_sts;
        8'h14:   reg_rdata = p_ena;
        8'h18:   reg_rdata = {27'd0, fre_q, 3'd0, st_q};
        8'h30:   reg_rdata = serr_q;
        8'h34:   reg_rdata = sact_q;
        8'h38:   reg_rdata = ci_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; rdata_q <= '0; pick_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (wr_go) state <= S_BRESP;
          else if (rd_go) begin
            if (win_onehot != '0) begin
              pick_q <= win_onehot;
              state  <= S_RAMWAIT;
            end else begin
              rdata_q <= reg_rdata;
              state   <= S_RDATA;
            end
          end
        end
        S_BRESP:   if (s_bready) state <= S_IDLE;
        S_RAMWAIT: begin
          rdata_q <= pick_q[0] ? fis_rdata : pick_q[1] ? cl_rdata : ct_rdata;
          state   <= S_RDATA;
        end
        S_RDATA:   if (s_rready) state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign hba_reset  = hr_q;
  assign port_fre   = fre_q;
  assign port_start = st_q;
  assign cmd_issue  = ci_q;
  assign cmd_active = sact_q;
  assign irq        = gie_q & pending;
endmodule

// File: rtl/hba_regfile_chk.sv
module hba_regfile_chk
  import hba_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WIN_N-1:0]  ram_sel,
  input logic              port_start,
  input logic              port_fre,
  input logic              hba_reset,
  input logic              hw_reset_done,
  input logic              ghc_wr,
  input logic [SLOTS-1:0]  cmd_issue,
  input logic [SLOTS-1:0]  hw_ci_clr,
  input logic              ci_wr,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic              pending,
  input logic              masked_any
);
  p_one_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_sel));

  p_reset_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hba_reset && hw_reset_done && !ghc_wr) |=> !hba_reset);

  p_pending_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && masked_any) |=> pending);

  p_start_needs_fre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    port_start |-> port_fre);

  p_issue_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ci_wr && hw_ci_clr != '0) |=> ((cmd_issue & $past(hw_ci_clr)) == '0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
endmodule

bind hba_regfile hba_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ram_sel(ram_sel), .port_start(port_start),
  .port_fre(port_fre), .hba_reset(hba_reset), .hw_reset_done(hw_reset_done),
  .ghc_wr(ghc_wr), .cmd_issue(cmd_issue), .hw_ci_clr(hw_ci_clr), .ci_wr(ci_wr),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .pending(pending), .masked_any(masked_any)
);

// File: tb/hba_regfile_bench.sv
module hba_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CAPV = 32'h4020_1F00;
  localparam logic [31:0] VERV = 32'h0001_0301;

  logic clk = 0, rst_n = 0;
  logic [16:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, arvalid = 0, bready = 1, rready = 1;
  logic [31:0] wdata = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [2:0] ram_sel; logic ram_we; logic [13:0] ram_addr; logic [31:0] ram_wdata;
  logic [31:0] fis_rd = '0, cl_rd = '0, ct_rd = '0;
  logic [31:0] is_set = '0, serr_set = '0, ci_clr = '0, sact_clr = '0;
  logic pcs = 0, prcs = 0, rst_done = 0;
  logic hba_reset, port_fre, port_start, irq;
  logic [31:0] cmd_issue, cmd_active;

  int checks = 0, errors = 0, ram_hits = 0;
  logic [2:0] last_sel; logic [13:0] last_addr; logic [31:0] last_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  hba_regfile u_hba_regfile (
    .clk(clk), .rst_n(rst_n), .s_awaddr(awaddr), .s_awvalid(awvalid),
    .s_awready(awready), .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready), .s_araddr(araddr),
    .s_arvalid(arvalid), .s_arready(arready), .s_rdata(rdata), .s_rresp(rresp),
    .s_rvalid(rvalid), .s_rready(rready), .ram_sel(ram_sel), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .fis_rdata(fis_rd),
    .cl_rdata(cl_rd), .ct_rdata(ct_rd), .hw_is_set(is_set), .hw_pcs(pcs),
    .hw_prcs(prcs), .hw_serr_set(serr_set), .hw_ci_clr(ci_clr),
    .hw_sact_clr(sact_clr), .hw_reset_done(rst_done), .hba_reset(hba_reset),
    .port_fre(port_fre), .port_start(port_start), .cmd_issue(cmd_issue),
    .cmd_active(cmd_active), .irq(irq)
  );

  function automatic logic [31:0] pat(input int w, input logic [13:0] a);
    return {4'hA, 2'(w), 12'h5C3, a};
  endfunction

  // RAM models: one cycle read latency; log writes
  always @(posedge clk) begin
    if (ram_sel != 0) ram_hits++;
    if (ram_sel[0]) fis_rd <= pat(0, ram_addr);
    if (ram_sel[1]) cl_rd  <= pat(1, ram_addr);
    if (ram_sel[2]) ct_rd  <= pat(2, ram_addr);
    if (ram_we) begin last_sel <= ram_sel; last_addr <= ram_addr; last_data <= ram_wdata; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [31:0] d);
    @(negedge clk); awaddr = a; wdata = d; awvalid = 1; wvalid = 1; #1;
    while (!awready) begin @(negedge clk); #1; end
    @(posedge clk); #1; awvalid = 0; wvalid = 0;
    @(negedge clk);
    while (!bvalid) @(negedge clk);
    if (bresp != 0) chk("R2 bresp", 32'(bresp), 0);
  endtask

  task automatic rd(input logic [16:0] a, output logic [31:0] d, output int lat);
    @(negedge clk); araddr = a; arvalid = 1; #1;
    while (!arready) begin @(negedge clk); #1; end
    @(posedge clk); #1; arvalid = 0; lat = 0;
    do begin @(negedge clk); lat++; end while (!rvalid && lat < 20);
    d = rdata;
    if (rresp != 0) chk("R2 rresp", 32'(rresp), 0);
  endtask

  task automatic rchk(input string tag, input logic [16:0] a, input logic [31:0] exp);
    logic [31:0] d; int lat;
    rd(a, d, lat);
    chk(tag, d, exp);
  endtask

  task automatic pulse_is(input logic [31:0] v);
    @(negedge clk); is_set = v; @(negedge clk); is_set = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, exp_ci; int lat, hits0;
    repeat (3) @(negedge clk); rst_n = 1;
    // reset state
    chk("R7 irq reset", 32'(irq), 0);
    chk("R9 issue reset", cmd_issue, 0);
    chk("R3 reset out", 32'(hba_reset), 0);
    // R12 fixed values, R11 register latency
    rd(17'h00000, d, lat); chk("R12 cap", d, CAPV); chk("R11 reg latency", lat, 1);
    rchk("R12 ports", 17'h0000C, 32'd1);
    rchk("R12 version", 17'h00010, VERV);
    // R5 mask
    rchk("R5 mask reset", 17'h00114, 0);
    wr(17'h00114, 32'hDEAD_BEEF); rchk("R5 mask rw", 17'h00114, 32'hDEAD_BEEF);
    // R1 window sweep and R2 reserved
    begin
      logic [16:0] addrs [11] = '{17'h08000, 17'h080FC, 17'h09000, 17'h093FC,
        17'h10000, 17'h1FFFC, 17'h08100, 17'h09400, 17'h0FFFC, 17'h00180, 17'h07FFC};
      for (int i = 0; i < 11; i++) begin
        int w; logic [13:0] wd;
        w = addrs[i] >= 17'h10000 ? 2 :
            (addrs[i] >= 17'h08000 && addrs[i] < 17'h08100) ? 0 :
            (addrs[i] >= 17'h09000 && addrs[i] < 17'h09400) ? 1 : -1;
        wd = w == 0 ? 14'((addrs[i] - 17'h08000) >> 2) :
             w == 1 ? 14'((addrs[i] - 17'h09000) >> 2) : 14'((addrs[i] - 17'h10000) >> 2);
        hits0 = ram_hits;
        rd(addrs[i], d, lat);
        if (w >= 0) begin
          chk("R1 window read", d, pat(w, wd));
          chk("R11 ram latency", lat, 2);
          wr(addrs[i], 32'h1234_0000 + 32'(i));
          chk("R1 write sel", 32'(last_sel), 32'(1 << w));
          chk("R1 write addr", 32'(last_addr), 32'(wd));
          chk("R1 write data", last_data, 32'h1234_0000 + 32'(i));
        end else begin
          chk("R2 reserved read", d, 0);
          wr(addrs[i], 32'hFFFF_FFFF);
          chk("R2 reserved no ram", ram_hits - hits0, 0);
        end
      end
    end
    rchk("R2 mask untouched", 17'h00114, 32'hDEAD_BEEF);
    // R3 reset handshake and enable bit
    wr(17'h00004, 32'h1); chk("R3 reset raised", 32'(hba_reset), 1);
    wr(17'h00004, 32'h0); chk("R3 write0 no effect", 32'(hba_reset), 1);
    @(negedge clk); rst_done = 1; @(negedge clk); rst_done = 0;
    chk("R3 reset lowered", 32'(hba_reset), 0);
    wr(17'h00004, 32'h2); rchk("R3 ie readback", 17'h00004, 32'h2);
    // R4/R6/R7 sweep over every status bit, six causes enabled
    wr(17'h00114, 32'h4140_0058);
    for (int b = 0; b < 32; b++) begin
      logic cause;
      cause = (b == 3) || (b == 4) || (b == 24) || (b == 30);
      pulse_is(32'(1) << b);
      @(negedge clk);
      rchk("R4 status set", 17'h00110, cause ? 32'(1) << b : 0);
      chk("R7 irq from cause", 32'(irq), 32'(cause));
      if (cause) begin
        wr(17'h00008, 32'h1);
        rchk("R6 flag held while cause", 17'h00008, 1);
        wr(17'h00110, 32'(1) << b);
        rchk("R4 w1c clears", 17'h00110, 0);
        rchk("R6 flag sticky", 17'h00008, 1);
        wr(17'h00008, 32'h1);
        rchk("R6 flag cleared", 17'h00008, 0);
        chk("R7 irq dropped", 32'(irq), 0);
      end
    end
    // masked cause does not pend
    wr(17'h00114, 32'h0000_0010); pulse_is(32'h8); @(negedge clk);
    rchk("R6 masked cause", 17'h00008, 0);
    wr(17'h00110, 32'h8);
    // read-only levels
    pcs = 1; prcs = 1; @(negedge clk);
    wr(17'h00110, 32'h0040_0040);
    rchk("R4 read-only levels", 17'h00110, 32'h0040_0040);
    pcs = 0; prcs = 0; @(negedge clk);
    rchk("R4 levels follow", 17'h00110, 0);
    // R7 global enable gate
    wr(17'h00114, 32'h8); pulse_is(32'h8); repeat (2) @(negedge clk);
    chk("R7 irq enabled", 32'(irq), 1);
    wr(17'h00004, 32'h0); chk("R7 irq gated", 32'(irq), 0);
    // R8 start needs frame receive
    wr(17'h00118, 32'h1);  chk("R8 start w/o fre", 32'(port_start), 0);
    wr(17'h00118, 32'h11); chk("R8 start", 32'(port_start), 1);
    rchk("R8 readback", 17'h00118, 32'h11);
    wr(17'h00118, 32'h1);  chk("R8 fre off drops start", 32'(port_start), 0);
    // R9 issue bitmap: OR-set, zeros ignored, per-slot clear sweep
    wr(17'h00138, 32'h5); wr(17'h00138, 32'h2); wr(17'h00138, 32'h0);
    chk("R9 or-set", cmd_issue, 32'h7);
    wr(17'h00138, 32'hFFFF_FFFF); exp_ci = 32'hFFFF_FFFF;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk); ci_clr = 32'(1) << k; @(negedge clk); ci_clr = 0;
      exp_ci = exp_ci & ~(32'(1) << k);
      chk("R9 issue clear", cmd_issue, exp_ci);
    end
    wr(17'h00134, 32'hA5A5_0000); wr(17'h00134, 32'h0000_00F0);
    @(negedge clk); sact_clr = 32'h8000_0010; @(negedge clk); sact_clr = 0;
    chk("R9 active", cmd_active, 32'h25A5_00E0);
    rchk("R9 active readback", 17'h00134, 32'h25A5_00E0);
    // R10 error register
    @(negedge clk); serr_set = 32'h0003_0100; @(negedge clk); serr_set = 0;
    rchk("R10 error set", 17'h00130, 32'h0003_0100);
    wr(17'h00130, 32'h0001_0100);
    rchk("R10 error w1c", 17'h00130, 32'h0002_0000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule